// File: doc/BRIEF.md
# Pixel Timestamp and Time-over-Threshold Cell

This block is the digital part of one pixel in a hybrid tracking detector. It takes a discriminator level that is already synchronous to the count clock. While the acquisition window is open, it records two things about the first hit: the coarse bunch time code present when the discriminator first rises, and how many count-clock cycles the discriminator then stays above threshold. The window spans one bunch train and is opened and closed by a shutter that is synchronised inside the pixel. No data leaves the pixel during the train.

Between trains the same 14-bit register becomes one stage of a serial chain that runs through the pixel matrix. A mode input moves the register onto a separate read clock. Bits arrive from the previous pixel and leave, most significant bit first, towards the next pixel. Per-pixel configuration bits can mask the pixel, replace the sensor signal with a test pulse, or invert the discriminator polarity.

Top module: `pixel_tot_cell`

## Requirements
- R1: After a synchronous active-low reset, the 14-bit register is all zeros and `ser_out` is 0.
- R2: On the first rising edge of the hit level inside an open window, `time_code` is latched into register bits 13:9. The periphery never drives code 0, which is reserved to mean "no hit".
- R3: Register bits 8:0 hold the time-over-threshold. This is the number of count-clock edges at which the hit level is high, starting with the edge that saw the rise and ending at the first edge where the level is low.
- R4: The time-over-threshold field saturates at 511 and never wraps.
- R5: Only the first hit in a window is recorded. Later rising edges leave both fields unchanged.
- R6: `shutter` passes through a two-stage synchroniser. The register is cleared on the third count-clock edge after `shutter` rises, and capture is possible from the fourth edge on. A hit whose rise comes before that edge is not recorded.
- R7: After `shutter` falls, counting continues for exactly two more count-clock edges and then stops, even if the hit level is still high.
- R8: With `read_mode` = 1, the register is clocked by `clk_read` and shifts towards bit 13 on each edge. `ser_in` enters bit 0 and `ser_out` always shows bit 13, so a word leaves most significant bit first. With `read_mode` = 0 and the shutter closed, the register holds its contents.
- R9: With `cfg_mask` = 1, neither the discriminator nor the test pulse can record a hit.
- R10: With `cfg_test` = 1, `test_pulse` replaces `disc` as the hit source, and `disc` is ignored.
- R11: With `cfg_polarity` = 1, the discriminator is active low.
- R12: A window with no recorded hit reads out as all zeros, even if the register held chain data before the window opened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_count | input | 1 | Count clock for acquisition |
| clk_read | input | 1 | Readout shift clock |
| rst_n | input | 1 | Synchronous active-low reset |
| read_mode | input | 1 | 1 selects readout shifting on clk_read; change only while both clocks are low |
| shutter | input | 1 | Asynchronous acquisition window |
| disc | input | 1 | Discriminator level, synchronous to clk_count |
| test_pulse | input | 1 | Test-injection level |
| cfg_mask | input | 1 | Pixel mask |
| cfg_test | input | 1 | Select test pulse as hit source |
| cfg_polarity | input | 1 | Invert discriminator |
| time_code | input | 5 | Shared coarse bunch time code |
| ser_in | input | 1 | Serial data from previous pixel |
| ser_out | output | 1 | Serial data to next pixel |

## Verification
The bench sweeps every non-zero time code with a different pulse length and reads each word back through the serial chain. A swapped or misaligned field, or a wrong bit order, would therefore show up as a wrong word. Saturation is probed at 510, 512 and 520 cycles, where a wrapping counter would read back a small value. It also tests a pulse that rises before the window opens, a pulse still high at shutter close, and a second pulse in the same window. A design that misses the synchroniser latency, keeps counting after close, or overwrites the first hit would read back a different count or time code. The chain check shifts a pattern in and reads it back. It then opens an empty window, and any stale data left in the register after the clear would read as non-zero.

// File: rtl/pixcell_pkg.sv
// Package: shared widths and the layout of the pixel data word.
// Assumes a timestamp field above a time-over-threshold field.
package pixcell_pkg;
    localparam int TS_W   = 5;
    localparam int TOT_W  = 9;
    localparam int WORD_W = TS_W + TOT_W;

    typedef struct packed {
        logic [TS_W-1:0]  ts;
        logic [TOT_W-1:0] tot;
    } pix_word_t;
endpackage

// File: rtl/pix_shutter_sync.sv
// Module: brings the asynchronous shutter into the count-clock domain.
// It produces a one-cycle window-start pulse and a window-active level.
// Assumes STAGES >= 2 synchroniser flops.
module pix_shutter_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shutter,
    output logic win_start,
    output logic win_active
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    // Synchroniser chain; stage 0 samples the asynchronous input.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[STAGES-2:0], shutter};
    end

    // Delayed copy of the synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    assign win_start  = sync_q[STAGES-1] & ~last_q;
    assign win_active = sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/pix_hit_front.sv
// Module: picks the hit source (sensor or test), applies polarity and
// mask, and detects the rising edge of the resulting hit level.
// Assumes disc and test_pulse are synchronous to clk.
module pix_hit_front (
    input  logic clk,
    input  logic rst_n,
    input  logic disc,
    input  logic test_pulse,
    input  logic cfg_mask,
    input  logic cfg_test,
    input  logic cfg_polarity,
    output logic hit_level,
    output logic hit_rise
);
    logic src_lvl;
    logic prev_q;

    // Source select with polarity on the sensor path and mask last.
    always_comb begin
        src_lvl   = cfg_test ? test_pulse : (disc ^ cfg_polarity);
        hit_level = src_lvl & ~cfg_mask;
    end

    // Previous hit level for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= hit_level;
    end

    assign hit_rise = hit_level & ~prev_q;
endmodule

// File: rtl/pix_data_reg.sv
// Module: the dual-use pixel register. During a window it captures the
// first hit's time code and counts its time-over-threshold with
// saturation. In read mode it is one stage of the serial chain, MSB out.
// Assumes clk is already the selected count or read clock.
module pix_data_reg
    import pixcell_pkg::*;
#(
    parameter int TSW  = TS_W,
    parameter int TOTW = TOT_W,
    localparam int W   = TSW + TOTW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            read_mode,
    input  logic            win_start,
    input  logic            win_active,
    input  logic            hit_level,
    input  logic            hit_rise,
    input  logic [TSW-1:0]  tcode,
    input  logic            sin,
    output logic [W-1:0]    word_q,
    output logic            captured,
    output logic            sout
);
    localparam logic [TOTW-1:0] TOT_MAX = '1;

    logic            counting;
    logic [W-1:0]    word_d;
    logic            captured_d;
    logic            counting_d;
    logic [TOTW-1:0] tot_cur;

    assign tot_cur = word_q[TOTW-1:0];

    // Next-state selection: shift, clear, capture, count, or hold.
    always_comb begin
        word_d     = word_q;
        captured_d = captured;
        counting_d = counting;
        if (read_mode) begin
            word_d = {word_q[W-2:0], sin};
        end else if (win_start) begin
            word_d     = '0;
            captured_d = 1'b0;
            counting_d = 1'b0;
        end else if (win_active) begin
            if (!captured && hit_rise) begin
                word_d     = {tcode, {{(TOTW-1){1'b0}}, 1'b1}};
                captured_d = 1'b1;
                counting_d = 1'b1;
            end else if (counting) begin
                if (hit_level) begin
                    if (tot_cur != TOT_MAX)
                        word_d[TOTW-1:0] = tot_cur + 1'b1;
                end else begin
                    counting_d = 1'b0;
                end
            end
        end else begin
            counting_d = 1'b0;
        end
    end

    // State register on the selected clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q   <= '0;
            captured <= 1'b0;
            counting <= 1'b0;
        end else begin
            word_q   <= word_d;
            captured <= captured_d;
            counting <= counting_d;
        end
    end

    assign sout = word_q[W-1];
endmodule

// File: rtl/pixel_tot_cell.sv
// Module: top of the pixel cell. It selects the count or read clock for
// the data register and wires the shutter synchroniser and hit front end.
// Assumes read_mode changes only while both clocks are low.
module pixel_tot_cell
    import pixcell_pkg::*;
#(
    parameter int TSW  = TS_W,
    parameter int TOTW = TOT_W
) (
    input  logic           clk_count,
    input  logic           clk_read,
    input  logic           rst_n,
    input  logic           read_mode,
    input  logic           shutter,
    input  logic           disc,
    input  logic           test_pulse,
    input  logic           cfg_mask,
    input  logic           cfg_test,
    input  logic           cfg_polarity,
    input  logic [TSW-1:0] time_code,
    input  logic           ser_in,
    output logic           ser_out
);
    localparam int W = TSW + TOTW;

    logic         reg_clk;
    logic         win_start;
    logic         win_active;
    logic         hit_level;
    logic         hit_rise;
    logic         captured;
    logic [W-1:0] word_q;

    // Clock select for the dual-use register.
    assign reg_clk = read_mode ? clk_read : clk_count;

    pix_shutter_sync #(.STAGES(2)) u_sync (
        .clk        (clk_count),
        .rst_n      (rst_n),
        .shutter    (shutter),
        .win_start  (win_start),
        .win_active (win_active)
    );

    pix_hit_front u_front (
        .clk          (clk_count),
        .rst_n        (rst_n),
        .disc         (disc),
        .test_pulse   (test_pulse),
        .cfg_mask     (cfg_mask),
        .cfg_test     (cfg_test),
        .cfg_polarity (cfg_polarity),
        .hit_level    (hit_level),
        .hit_rise     (hit_rise)
    );

    pix_data_reg #(.TSW(TSW), .TOTW(TOTW)) u_reg (
        .clk        (reg_clk),
        .rst_n      (rst_n),
        .read_mode  (read_mode),
        .win_start  (win_start),
        .win_active (win_active),
        .hit_level  (hit_level),
        .hit_rise   (hit_rise),
        .tcode      (time_code),
        .sin        (ser_in),
        .word_q     (word_q),
        .captured   (captured),
        .sout       (ser_out)
    );
endmodule

// File: rtl/pixel_tot_cell_chk.sv
// Module: property checker for the pixel cell, bound to the top.
// Assumes it is clocked by the same selected clock as the data register.
module pixel_tot_cell_chk #(
    parameter int TSW  = 5,
    parameter int TOTW = 9,
    localparam int W   = TSW + TOTW
) (
    input logic         clk,
    input logic         rst_n,
    input logic         read_mode,
    input logic         win_start,
    input logic         win_active,
    input logic         cfg_mask,
    input logic         captured,
    input logic         ser_in,
    input logic [W-1:0] word_q
);
    // R4: outside readout and clear, the ToT field never goes down.
    p_tot_monotonic_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!read_mode && !win_start) |=> (word_q[TOTW-1:0] >= $past(word_q[TOTW-1:0])));

    // R5: a captured time code is not overwritten by later hits.
    p_ts_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (captured && !read_mode && !win_start) |=> $stable(word_q[W-1:TOTW]));

    // R8: in read mode each edge moves the word up one place and takes ser_in.
    p_shift_chain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        read_mode |=> (word_q == {$past(word_q[W-2:0]), $past(ser_in)}));

    // R9: a masked pixel with nothing captured stays empty.
    p_mask_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mask && !captured) |=> !captured);

    // R12: during an open window with no capture the word is zero.
    p_empty_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (win_active && !captured && !read_mode) |-> (word_q == '0));
endmodule

bind pixel_tot_cell pixel_tot_cell_chk #(.TSW(TSW), .TOTW(TOTW)) u_chk (
    .clk        (reg_clk),
    .rst_n      (rst_n),
    .read_mode  (read_mode),
    .win_start  (win_start),
    .win_active (win_active),
    .cfg_mask   (cfg_mask),
    .captured   (captured),
    .ser_in     (ser_in),
    .word_q     (word_q)
);

// File: tb/pixel_tot_cell_test.sv
module pixel_tot_cell_test;
    localparam int CLK_PERIOD = 10;

    logic       clk_count = 1'b0;
    logic       clk_read = 1'b0;
    logic       rst_n = 1'b0;
    logic       read_mode = 1'b0;
    logic       shutter = 1'b0;
    logic       disc = 1'b0;
    logic       test_pulse = 1'b0;
    logic       cfg_mask = 1'b0;
    logic       cfg_test = 1'b0;
    logic       cfg_polarity = 1'b0;
    logic [4:0] time_code = 5'd1;
    logic       ser_in = 1'b0;
    logic       ser_out;

    int checks = 0;
    int errors = 0;
    logic [13:0] got;

    pixel_tot_cell uut (
        .clk_count(clk_count), .clk_read(clk_read), .rst_n(rst_n),
        .read_mode(read_mode), .shutter(shutter), .disc(disc),
        .test_pulse(test_pulse), .cfg_mask(cfg_mask), .cfg_test(cfg_test),
        .cfg_polarity(cfg_polarity), .time_code(time_code),
        .ser_in(ser_in), .ser_out(ser_out)
    );

    always #(CLK_PERIOD/2) clk_count = ~clk_count;

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk_count);
    endtask

    task automatic check(input string tag, input logic [13:0] act, input logic [13:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Shift the word out MSB first while feeding pat in from ser_in.
    task automatic read_word(output logic [13:0] w, input logic [13:0] pat);
        @(negedge clk_count);
        read_mode = 1'b1;
        w = '0;
        for (int i = 0; i < 14; i++) begin
            #1;
            w = {w[12:0], ser_out};
            ser_in = pat[13-i];
            #1 clk_read = 1'b1;
            #2 clk_read = 1'b0;
        end
        @(negedge clk_count);
        read_mode = 1'b0;
        ser_in = 1'b0;
    endtask

    task automatic open_win();
        shutter = 1'b1;
        tick(4);
    endtask

    task automatic close_win();
        shutter = 1'b0;
        tick(4);
    endtask

    // Active phase of len cycles on the chosen source; time code moves after the rise.
    task automatic pulse(input logic use_test, input logic [4:0] ts, input int len, input logic idle);
        time_code = ts;
        if (use_test) test_pulse = 1'b1; else disc = ~idle;
        tick(1);
        time_code = (ts == 5'd31) ? 5'd1 : ts + 5'd1;
        tick(len - 1);
        if (use_test) test_pulse = 1'b0; else disc = idle;
        tick(2);
    endtask

    function automatic logic [13:0] expect_word(input logic [4:0] ts, input int len);
        int t;
        t = (len > 511) ? 511 : len;
        return {ts, t[8:0]};
    endfunction

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: reset state
        check("R1 ser_out after reset", {13'd0, ser_out}, 14'd0);
        read_word(got, 14'd0);
        check("R1 word after reset", got, 14'd0);

        // R2 and R3: sweep every non-zero time code with varied length
        for (int t = 1; t < 32; t++) begin
            int len;
            len = (t * 7) % 23 + 1;
            open_win();
            pulse(1'b0, t[4:0], len, 1'b0);
            close_win();
            read_word(got, 14'd0);
            check($sformatf("R2 R3 ts=%0d len=%0d", t, len), got, expect_word(t[4:0], len));
        end

        // R4: saturation around the field limit
        open_win(); pulse(1'b0, 5'd9, 510, 1'b0); close_win();
        read_word(got, 14'd0);
        check("R4 len 510", got, expect_word(5'd9, 510));
        open_win(); pulse(1'b0, 5'd10, 512, 1'b0); close_win();
        read_word(got, 14'd0);
        check("R4 len 512 saturates", got, {5'd10, 9'd511});
        open_win(); pulse(1'b0, 5'd11, 520, 1'b0); close_win();
        read_word(got, 14'd0);
        check("R4 len 520 saturates", got, {5'd11, 9'd511});

        // R5: second hit in the same window is ignored
        open_win();
        pulse(1'b0, 5'd4, 3, 1'b0);
        tick(2);
        pulse(1'b0, 5'd20, 7, 1'b0);
        close_win();
        read_word(got, 14'd0);
        check("R5 first hit kept", got, {5'd4, 9'd3});

        // R6: rise before the window opens is not recorded
        shutter = 1'b1;
        disc = 1'b1;
        tick(6);
        disc = 1'b0;
        tick(2);
        close_win();
        read_word(got, 14'd0);
        check("R6 early rise ignored", got, 14'd0);

        // R6: rise on the first capture edge is recorded
        shutter = 1'b1;
        tick(3);
        pulse(1'b0, 5'd6, 4, 1'b0);
        close_win();
        read_word(got, 14'd0);
        check("R6 first capture edge", got, {5'd6, 9'd4});

        // R7: counting stops two edges after shutter falls
        open_win();
        time_code = 5'd12;
        disc = 1'b1;
        tick(5);
        shutter = 1'b0;
        tick(4);
        disc = 1'b0;
        tick(2);
        read_word(got, 14'd0);
        check("R7 stop at close", got, {5'd12, 9'd7});

        // R8: chain pattern shifts in, holds, and shifts back out
        read_word(got, 14'h2A5C);
        check("R8 word before chain", got, 14'd0);
        tick(5);
        read_word(got, 14'h0000);
        check("R8 chain pattern", got, 14'h2A5C);

        // R12: an empty window clears chain data
        read_word(got, 14'h3FFF);
        open_win();
        close_win();
        read_word(got, 14'd0);
        check("R12 empty window zero", got, 14'd0);

        // R9: mask blocks sensor and test sources
        cfg_mask = 1'b1;
        open_win();
        pulse(1'b0, 5'd3, 5, 1'b0);
        cfg_test = 1'b1;
        pulse(1'b1, 5'd5, 5, 1'b0);
        close_win();
        cfg_test = 1'b0;
        cfg_mask = 1'b0;
        read_word(got, 14'd0);
        check("R9 masked", got, 14'd0);

        // R10: test source used, sensor ignored
        cfg_test = 1'b1;
        open_win();
        pulse(1'b0, 5'd2, 4, 1'b0);
        pulse(1'b1, 5'd17, 6, 1'b0);
        close_win();
        cfg_test = 1'b0;
        read_word(got, 14'd0);
        check("R10 test pulse", got, {5'd17, 9'd6});

        // R11: active-low discriminator
        cfg_polarity = 1'b1;
        disc = 1'b1;
        tick(2);
        open_win();
        pulse(1'b0, 5'd25, 8, 1'b1);
        close_win();
        read_word(got, 14'd0);
        check("R11 inverted polarity", got, {5'd25, 9'd8});
        cfg_polarity = 1'b0;
        disc = 1'b0;

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule